// File: doc/BRIEF.md
# Memory Region Decoder with Attributes

This block sits in the address path of a 32-bit system bus. In the address phase it splits the address into a fixed set of architectural regions. The decoded region identifier, a one-hot region select and the attributes of the region are registered into the data phase. The attributes are memory type, cache policy, shareable, execute-never and bufferable. Downstream slaves use the select. Caches and write buffers use the attributes to decide how to treat the transfer.

Two kinds of access are refused with a bus error: any access into the unused space at the top of the map, and an instruction fetch into a region that is marked execute-never. An error is signalled with a two-cycle response. In the first cycle, ready is low and error is high. In the second cycle, both are high. An idle cycle, where valid is low, is decoded but never faults.

Top module: `mem_region_decoder`

## Requirements
- R1: A transfer accepted while `ready_o` is high appears on the outputs one clock later. `region_o` is coded as follows: code 0 (0x00000000–0x1FFFFFFF), SRAM 1 (0x20000000–0x3FFFFFFF), peripheral 2 (0x40000000–0x5FFFFFFF), RAM write-back 3 (0x60000000–0x7FFFFFFF), RAM write-through 4 (0x80000000–0x9FFFFFFF), shareable device 5 (0xA0000000–0xBFFFFFFF), non-shareable device 6 (0xC0000000–0xDFFFFFFF), private peripheral 7 (0xE0000000–0xE00FFFFF), reserved 8 (0xE0100000–0xFFFFFFFF). `size_o` carries the accepted `size_i`.
- R2: `sel_o` has bit N set, where N is the region code, only for a valid transfer that does not fault. `sel_o` is all zero for idle transfers, for faulting transfers and for reserved space.
- R3: The code region is normal memory (`mtype_o`=0) with write-through caching (`cache_o`=1). SRAM is normal memory with write-back write-allocate caching (`cache_o`=2). The peripheral region is device memory (`mtype_o`=1), uncached (`cache_o`=0) and execute-never. None of these three is shareable.
- R4: The lower half of the RAM region is normal memory with write-back write-allocate caching. The upper half is normal memory with write-through caching. Both are executable and non-shareable.
- R5: The lower half of the device region is shareable device memory. The upper half is non-shareable device memory. Both are uncached and execute-never.
- R6: The private peripheral range is strongly ordered (`mtype_o`=2), shareable, execute-never, uncached and non-bufferable (`buf_o`=0). Every non-reserved region other than this one has `buf_o`=1. Reserved space reports `mtype_o`=3, uncached, execute-never, non-shareable and `buf_o`=0.
- R7: A valid access of any kind into reserved space produces an error response.
- R8: A valid instruction fetch (`fetch_i`=1) into an execute-never region produces an error response. A data access to the same region does not. A fetch into an executable region does not.
- R9: An error response is two cycles long. In the first cycle `ready_o`=0 and `err_o`=1, and the outputs keep the values of the faulting transfer. In the second cycle `ready_o`=1 and `err_o`=1, and inputs are accepted again. Inputs offered while `ready_o`=0 are ignored.
- R10: A transfer with `valid_i` low never produces an error, whatever its address and fetch flag.
- R11: After reset, `ready_o`=1, `err_o`=0, `sel_o`=0, `region_o`=0 and `size_o`=0, and all attribute outputs are 0.
- R12: The private peripheral range ends exactly at 0xE00FFFFF. 0xE0100000 is already reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 32 | Address-phase address |
| valid_i | input | 1 | Transfer valid (low = idle) |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| size_i | input | 2 | Transfer size, carried to the data phase |
| ready_o | output | 1 | Low in the first cycle of an error response |
| err_o | output | 1 | Error response, high for both error cycles |
| region_o | output | 4 | Data-phase region code |
| sel_o | output | 8 | One-hot region select |
| mtype_o | output | 2 | Memory type: 0 normal, 1 device, 2 strongly ordered, 3 reserved |
| cache_o | output | 2 | Cache policy: 0 none, 1 write-through, 2 write-back write-allocate |
| share_o | output | 1 | Shareable |
| xn_o | output | 1 | Execute-never |
| buf_o | output | 1 | Bufferable |
| size_o | output | 2 | Data-phase transfer size |

## Verification
Addresses at the first and last byte of every region tell a correct boundary from an off-by-one in the top-bit decode. The pair 0xE00FFFFF and 0xE0100000 isolates the narrow private peripheral window. The same execute-never address is offered once as a data access and once as a fetch, which separates the permission check from plain decoding. The same reserved address is offered as a valid access and as an idle one, which separates the fault path from the valid gate. Faults are placed back to back and with valid traffic offered during the not-ready cycle, which shows that the two-cycle response holds its data-phase values and ignores inputs while `ready_o` is low.

// File: rtl/mrd_pkg.sv
// Shared types for the memory region decoder.
// Assumes a 32-bit map split on the top three address bits.
package mrd_pkg;
    localparam int NUM_REGIONS = 9;
    localparam int NUM_SEL     = NUM_REGIONS - 1;
    localparam int RGN_W       = $clog2(NUM_REGIONS);

    typedef enum logic [RGN_W-1:0] {
        RGN_CODE    = 4'd0,
        RGN_SRAM    = 4'd1,
        RGN_PERIPH  = 4'd2,
        RGN_RAM_WB  = 4'd3,
        RGN_RAM_WT  = 4'd4,
        RGN_DEV_SH  = 4'd5,
        RGN_DEV_NSH = 4'd6,
        RGN_PRIV    = 4'd7,
        RGN_RSVD    = 4'd8
    } region_e;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEVICE = 2'd1,
        MT_STRONG = 2'd2,
        MT_RSVD   = 2'd3
    } mtype_e;

    typedef enum logic [1:0] {
        CP_NONE = 2'd0,
        CP_WT   = 2'd1,
        CP_WBWA = 2'd2
    } cache_e;

    typedef struct packed {
        mtype_e mtype;
        cache_e cache;
        logic   share;
        logic   xn;
        logic   bufable;
    } attr_t;
endpackage

// File: rtl/mrd_region_lookup.sv
// Region lookup: maps the upper address bits onto a region code.
// Assumes the private peripheral window starts at the base of the top
// eighth of the map and spans 2**PPB_W bytes; the rest of that eighth is reserved.
module mrd_region_lookup
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PPB_W  = 20
) (
    input  logic [ADDR_W-1:PPB_W] addr_hi_i,
    output region_e               region_o
);
    localparam int TOP_LSB = ADDR_W - 3;

    logic [2:0] top_bits;
    logic       priv_hit;

    assign top_bits = addr_hi_i[ADDR_W-1:TOP_LSB];
    assign priv_hit = (addr_hi_i[TOP_LSB-1:PPB_W] == '0);

    // Select the region from the eighth of the map and the window test.
    always_comb begin
        unique case (top_bits)
            3'd0:    region_o = RGN_CODE;
            3'd1:    region_o = RGN_SRAM;
            3'd2:    region_o = RGN_PERIPH;
            3'd3:    region_o = RGN_RAM_WB;
            3'd4:    region_o = RGN_RAM_WT;
            3'd5:    region_o = RGN_DEV_SH;
            3'd6:    region_o = RGN_DEV_NSH;
            default: region_o = priv_hit ? RGN_PRIV : RGN_RSVD;
        endcase
    end
endmodule

// File: rtl/mrd_attr_table.sv
// Attribute table: fixed attributes for each region code.
// Assumes a purely combinational lookup with no configuration.
module mrd_attr_table
    import mrd_pkg::*;
(
    input  region_e region_i,
    output attr_t   attr_o
);
    // Return the attributes of the given region.
    always_comb begin
        unique case (region_i)
            RGN_CODE:    attr_o = '{MT_NORMAL, CP_WT,   1'b0, 1'b0, 1'b1};
            RGN_SRAM:    attr_o = '{MT_NORMAL, CP_WBWA, 1'b0, 1'b0, 1'b1};
            RGN_PERIPH:  attr_o = '{MT_DEVICE, CP_NONE, 1'b0, 1'b1, 1'b1};
            RGN_RAM_WB:  attr_o = '{MT_NORMAL, CP_WBWA, 1'b0, 1'b0, 1'b1};
            RGN_RAM_WT:  attr_o = '{MT_NORMAL, CP_WT,   1'b0, 1'b0, 1'b1};
            RGN_DEV_SH:  attr_o = '{MT_DEVICE, CP_NONE, 1'b1, 1'b1, 1'b1};
            RGN_DEV_NSH: attr_o = '{MT_DEVICE, CP_NONE, 1'b0, 1'b1, 1'b1};
            RGN_PRIV:    attr_o = '{MT_STRONG, CP_NONE, 1'b1, 1'b1, 1'b0};
            default:     attr_o = '{MT_RSVD,   CP_NONE, 1'b0, 1'b1, 1'b0};
        endcase
    end
endmodule

// File: rtl/mrd_err_seq.sv
// Error sequencer: produces the two-cycle error response.
// Assumes bad_i is already the combined fault condition of the offered
// transfer; the sequencer gates it with valid_i and with its own ready.
module mrd_err_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic bad_i,
    output logic ready_o,
    output logic err_o
);
    typedef enum logic [1:0] {ES_IDLE, ES_FIRST, ES_SECOND} err_state_e;

    err_state_e state_q, state_d;

    // Next state: a faulting accepted transfer starts the response.
    always_comb begin
        if (state_q == ES_FIRST)            state_d = ES_SECOND;
        else if (valid_i && bad_i)          state_d = ES_FIRST;
        else                                state_d = ES_IDLE;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ES_IDLE;
        else        state_q <= state_d;
    end

    assign ready_o = (state_q != ES_FIRST);
    assign err_o   = (state_q != ES_IDLE);

    AST_ERR_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (ready_o && err_o)); // R9
    AST_NOT_READY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> err_o); // R9
    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !valid_i) |=> ready_o); // R10
endmodule

// File: rtl/mem_region_decoder.sv
// Memory region decoder: decodes the address phase, registers region,
// select and attributes into the data phase, and raises bus errors for
// reserved space and for fetches from execute-never regions.
// Assumes the registers load only while ready_o is high.
module mem_region_decoder
    import mrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2,
    parameter int PPB_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_i,
    input  logic              fetch_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              ready_o,
    output logic              err_o,
    output logic [RGN_W-1:0]  region_o,
    output logic [NUM_SEL-1:0] sel_o,
    output logic [1:0]        mtype_o,
    output logic [1:0]        cache_o,
    output logic              share_o,
    output logic              xn_o,
    output logic              buf_o,
    output logic [SIZE_W-1:0] size_o
);
    region_e      region_d, region_q;
    attr_t        attr_d, attr_q;
    logic         bad_d;
    logic [NUM_SEL-1:0] sel_d, sel_q;
    logic [SIZE_W-1:0]  size_q;

    mrd_region_lookup #(.ADDR_W(ADDR_W), .PPB_W(PPB_W)) u_lookup (
        .addr_hi_i (addr_i[ADDR_W-1:PPB_W]),
        .region_o  (region_d)
    );

    mrd_attr_table u_attr (
        .region_i (region_d),
        .attr_o   (attr_d)
    );

    assign bad_d = (region_d == RGN_RSVD) || (fetch_i && attr_d.xn);

    mrd_err_seq u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i && ready_o),
        .bad_i   (bad_d),
        .ready_o (ready_o),
        .err_o   (err_o)
    );

    // One select line per selectable region code.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_d[g] = valid_i && !bad_d && (region_d == region_e'(g));
    end

    // Data-phase registers, loaded only while the bus is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= RGN_CODE;
            attr_q   <= '0;
            sel_q    <= '0;
            size_q   <= '0;
        end else if (ready_o) begin
            region_q <= region_d;
            attr_q   <= attr_d;
            sel_q    <= sel_d;
            size_q   <= size_i;
        end
    end

    assign region_o = region_q;
    assign sel_o    = sel_q;
    assign mtype_o  = attr_q.mtype;
    assign cache_o  = attr_q.cache;
    assign share_o  = attr_q.share;
    assign xn_o     = attr_q.xn;
    assign buf_o    = attr_q.bufable;
    assign size_o   = size_q;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R2
    AST_FAULT_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !ready_o) |-> (sel_o == '0)); // R2
    AST_STRONG_NO_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (mtype_o == MT_STRONG) |-> (!buf_o && cache_o == CP_NONE)); // R6
    AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i && addr_i >= ADDR_W'(32'hE010_0000)) |=> (err_o && !ready_o)); // R7
    AST_FETCH_XN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i && fetch_i) |=> (xn_o == (err_o && !ready_o))); // R8
endmodule

// File: tb/mem_region_decoder_bench.sv
module mem_region_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr_i = '0;
    logic        valid_i = 1'b0;
    logic        fetch_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        ready_o, err_o, share_o, xn_o, buf_o;
    logic [3:0]  region_o;
    logic [7:0]  sel_o;
    logic [1:0]  mtype_o, cache_o, size_o;

    always #2 clk = ~clk;

    mem_region_decoder u_mem_region_decoder (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .valid_i(valid_i),
        .fetch_i(fetch_i), .size_i(size_i), .ready_o(ready_o), .err_o(err_o),
        .region_o(region_o), .sel_o(sel_o), .mtype_o(mtype_o), .cache_o(cache_o),
        .share_o(share_o), .xn_o(xn_o), .buf_o(buf_o), .size_o(size_o)
    );

    typedef struct {
        logic [31:0] packed_out;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Bench model state: current output phase and held data-phase values.
    int          ph = 0;
    logic [3:0]  h_rgn = 0;
    logic [7:0]  h_sel = 0;
    logic [1:0]  h_mt = 0, h_cp = 0, h_sz = 0;
    logic        h_sh = 0, h_xn = 0, h_bf = 0;

    function automatic logic [31:0] pack_out(logic rdy, logic er, logic [3:0] rg,
            logic [7:0] sl, logic [1:0] mt, logic [1:0] cp, logic sh, logic xn,
            logic bf, logic [1:0] sz);
        return {8'd0, rdy, er, rg, sl, mt, cp, sh, xn, bf, sz, 1'b0};
    endfunction

    function automatic logic [31:0] dut_out();
        return pack_out(ready_o, err_o, region_o, sel_o, mtype_o, cache_o,
                        share_o, xn_o, buf_o, size_o);
    endfunction

    // Expected region code and attributes from the requirement ranges.
    task automatic model(input logic [31:0] a, output logic [3:0] rg,
            output logic [1:0] mt, output logic [1:0] cp, output logic sh,
            output logic xn, output logic bf);
        if      (a <= 32'h1FFF_FFFF) begin rg = 0; mt = 0; cp = 1; sh = 0; xn = 0; bf = 1; end
        else if (a <= 32'h3FFF_FFFF) begin rg = 1; mt = 0; cp = 2; sh = 0; xn = 0; bf = 1; end
        else if (a <= 32'h5FFF_FFFF) begin rg = 2; mt = 1; cp = 0; sh = 0; xn = 1; bf = 1; end
        else if (a <= 32'h7FFF_FFFF) begin rg = 3; mt = 0; cp = 2; sh = 0; xn = 0; bf = 1; end
        else if (a <= 32'h9FFF_FFFF) begin rg = 4; mt = 0; cp = 1; sh = 0; xn = 0; bf = 1; end
        else if (a <= 32'hBFFF_FFFF) begin rg = 5; mt = 1; cp = 0; sh = 1; xn = 1; bf = 1; end
        else if (a <= 32'hDFFF_FFFF) begin rg = 6; mt = 1; cp = 0; sh = 0; xn = 1; bf = 1; end
        else if (a <= 32'hE00F_FFFF) begin rg = 7; mt = 2; cp = 0; sh = 1; xn = 1; bf = 0; end
        else                         begin rg = 8; mt = 3; cp = 0; sh = 0; xn = 1; bf = 0; end
    endtask

    // Driver: offers one transfer and queues the outputs it must produce.
    task automatic step(input logic [31:0] a, input logic v, input logic f,
            input logic [1:0] sz, input string tag);
        logic [3:0] rg; logic [1:0] mt, cp; logic sh, xn, bf, bad;
        exp_t e;
        @(negedge clk);
        addr_i = a; valid_i = v; fetch_i = f; size_i = sz;
        if (ph == 1) begin
            ph = 2;
            e.packed_out = pack_out(1'b1, 1'b1, h_rgn, h_sel, h_mt, h_cp, h_sh, h_xn, h_bf, h_sz);
        end else begin
            model(a, rg, mt, cp, sh, xn, bf);
            bad = v && (rg == 8 || (f && xn));
            h_rgn = rg; h_mt = mt; h_cp = cp; h_sh = sh; h_xn = xn; h_bf = bf; h_sz = sz;
            h_sel = (v && !bad) ? (8'd1 << rg) : 8'd0;
            ph = bad ? 1 : 0;
            e.packed_out = pack_out(!bad, bad, h_rgn, h_sel, h_mt, h_cp, h_sh, h_xn, h_bf, h_sz);
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares each queued item one step after its clock edge.
    initial begin
        exp_t e;
        logic [31:0] got;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                got = dut_out();
                n_checks++;
                if (got !== e.packed_out) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", e.tag, got, e.packed_out);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, exp_rst;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        got = dut_out();
        exp_rst = pack_out(1'b1, 1'b0, 4'd0, 8'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        n_checks++;
        if (got !== exp_rst) begin
            n_fail++;
            $display("FAIL R11: actual %h expected %h", got, exp_rst);
        end

        step(32'h0000_0100, 1, 0, 2'd2, "R1 R3 code data");
        step(32'h1FFF_FFFC, 1, 1, 2'd2, "R3 R8 code fetch");
        step(32'h2000_0000, 1, 1, 2'd1, "R3 sram fetch");
        step(32'h4000_1000, 1, 0, 2'd2, "R3 R8 periph data");
        step(32'h5FFF_FFFC, 1, 1, 2'd1, "R8 periph fetch fault");
        step(32'h2000_0040, 1, 0, 2'd0, "R9 first cycle ignores input");
        step(32'h0000_0000, 0, 0, 2'd0, "R9 second cycle");
        step(32'h6000_0000, 1, 0, 2'd2, "R4 ram wb low");
        step(32'h7FFF_FFFF, 1, 0, 2'd0, "R4 ram wb top");
        step(32'h8000_0000, 1, 1, 2'd2, "R4 ram wt base");
        step(32'h9FFF_FFFC, 1, 1, 2'd2, "R4 ram wt fetch");
        step(32'hA000_0000, 1, 0, 2'd2, "R5 dev shareable");
        step(32'hBFFF_FFFF, 1, 0, 2'd0, "R5 dev shareable top");
        step(32'hC000_0000, 1, 0, 2'd1, "R5 dev nonshareable");
        step(32'hDFFF_FFFC, 1, 1, 2'd2, "R5 R8 dev fetch fault");
        step(32'h0000_0000, 0, 0, 2'd0, "R9 first");
        step(32'h0000_0000, 0, 0, 2'd0, "R9 second");
        step(32'hE000_0000, 1, 0, 2'd2, "R6 private base");
        step(32'hE000_E010, 1, 0, 2'd2, "R6 private mid");
        step(32'hE00F_FFFF, 1, 0, 2'd0, "R12 private top");
        step(32'hE010_0000, 1, 0, 2'd2, "R12 R7 reserved base");
        step(32'hF000_0000, 1, 0, 2'd2, "R9 first holds");
        step(32'hFFFF_FFFF, 1, 0, 2'd0, "R7 back-to-back fault in second cycle");
        step(32'h0000_0000, 0, 0, 2'd0, "R9 first");
        step(32'hFFFF_FFFF, 0, 1, 2'd3, "R10 idle reserved fetch");
        step(32'hE010_0000, 0, 0, 2'd1, "R10 R2 idle reserved");
        step(32'h5000_0000, 0, 1, 2'd2, "R10 idle xn fetch");
        step(32'h2000_0004, 1, 0, 2'd2, "R2 sram select");
        step(32'h0000_0000, 0, 0, 2'd0, "R2 idle drain");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule